// File: doc/BRIEF.md
# Set/Clear Interrupt Aggregator

This block is a second-level interrupt collector. It watches a vector of interrupt sources and latches a pending bit whenever a source makes a rising transition. It merges every pending line that is not disabled into a single request toward a parent interrupt controller.

Software sees two 32-bit words over a plain register port: the pending word and the disable word. It can read each word directly. It changes them only through dedicated write-one-to-set and write-one-to-clear alias addresses, so no read-modify-write is ever needed. A disable bit of 1 blocks its line from the output. A blocked line still records its events, so unblocking it later raises the request if the event was never acknowledged.

The register port is combinational on reads and takes effect on the clock edge for writes. The request output is registered.

Top module: `sc_irq_aggregator`

## Requirements
- R1: After synchronous reset, the pending word (read at offset 0x00) is all zeros, the disable word (read at offset 0x0C) is all ones, and `irq_o` is low.
- R2: A 0-to-1 transition on `src_i[n]` sets pending bit n at the next clock edge. The bit stays set after the source returns low.
- R3: A write to offset 0x08 clears every pending bit written as 1. Bits written as 0 are left unchanged.
- R4: A write to offset 0x04 sets every pending bit written as 1. Bits written as 0 are left unchanged.
- R5: A write to offset 0x10 sets disable bits written as 1. A write to offset 0x14 clears disable bits written as 1. Zero bits have no effect in either case.
- R6: A disabled line still latches pending events. Clearing its disable bit while it is pending raises `irq_o`.
- R7: `irq_o` equals the OR of (pending AND NOT disable) as it stood one clock earlier.
- R8: When a new source edge and a pending-clear write hit the same bit in the same cycle, the bit ends up set.
- R9: Reads of offsets 0x04, 0x08, 0x10 and 0x14, and of any unmapped offset, return 0. Writes to unmapped offsets change neither word.
- R10: A source held high produces one event only. Once that event is cleared, the bit stays clear until the source falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Interrupt source levels, one per line |
| bus_addr | input | 5 | Byte offset of the register access |
| bus_wen | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Registered request to the parent controller |

## Verification
Random source vectors are driven alongside random writes to every alias and to unmapped offsets. Comparing reads and `irq_o` against a bench model separates correct set/clear masking from whole-word overwrites. Directed sequences target the cases random traffic rarely hits:
- an edge landing on the same bit as a clear write, which distinguishes edge-wins priority from clear-wins;
- a source held high across a clear, which distinguishes edge detection from level sampling;
- a disabled line that is later enabled, which shows that latching is independent of the disable word.

// File: rtl/sc_irq_pkg.sv
package sc_irq_pkg;
    localparam int LINES  = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_PEND     = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND_SET = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_PEND_CLR = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_DIS      = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_DIS_SET  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_DIS_CLR  = 5'h14;

    typedef logic [LINES-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t pend_set;
        line_vec_t pend_clr;
        line_vec_t dis_set;
        line_vec_t dis_clr;
    } wr_strobe_t;

    function automatic line_vec_t gate_bits(input logic en, input line_vec_t bits);
        return en ? bits : '0;
    endfunction
endpackage

// File: rtl/sc_edge_detect.sv
module sc_edge_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl_i;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign rise_o[b] = lvl_i[b] & ~lvl_q[b];
    end

    // R10: a rising pulse never lasts two consecutive cycles
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/sc_setclr_word.sv
module sc_setclr_word #(
    parameter int               WIDTH     = 32,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] q_d;

    // set has priority over clear
    always_comb q_d = (q_o & ~clr_i) | set_i;

    always_ff @(posedge clk) begin
        if (rst) q_o <= RESET_VAL;
        else     q_o <= q_d;
    end

    assert_set_bits_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q_o & $past(set_i)) == $past(set_i)));
    assert_clear_bits_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q_o & $past(clr_i & ~set_i)) == '0));
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/sc_reg_port.sv
module sc_reg_port
    import sc_irq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic       [AW-1:0]    addr_i,
    input  logic                   wen_i,
    input  line_vec_t              wdata_i,
    input  line_vec_t              pend_i,
    input  line_vec_t              dis_i,
    output wr_strobe_t             stb_o,
    output line_vec_t              rdata_o
);
    always_comb begin
        stb_o.pend_set = gate_bits(wen_i && addr_i == OFS_PEND_SET, wdata_i);
        stb_o.pend_clr = gate_bits(wen_i && addr_i == OFS_PEND_CLR, wdata_i);
        stb_o.dis_set  = gate_bits(wen_i && addr_i == OFS_DIS_SET,  wdata_i);
        stb_o.dis_clr  = gate_bits(wen_i && addr_i == OFS_DIS_CLR,  wdata_i);
    end

    always_comb begin
        case (addr_i)
            OFS_PEND: rdata_o = pend_i;
            OFS_DIS:  rdata_o = dis_i;
            default:  rdata_o = '0;
        endcase
    end

    // R9: only one write alias can be active per cycle
    always_comb begin
        assert_one_alias_R9: assert ($countones({|stb_o.pend_set, |stb_o.pend_clr,
                                                 |stb_o.dis_set, |stb_o.dis_clr}) <= 1);
    end
endmodule

// File: rtl/sc_irq_aggregator.sv
module sc_irq_aggregator
    import sc_irq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] src_i,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wen,
    input  logic [LINES-1:0] bus_wdata,
    output logic [LINES-1:0] bus_rdata,
    output logic             irq_o
);
    line_vec_t  rise;
    line_vec_t  pend;
    line_vec_t  dis;
    line_vec_t  pend_set_all;
    wr_strobe_t stb;

    sc_edge_detect #(.WIDTH(LINES)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (src_i),
        .rise_o(rise)
    );

    sc_reg_port #(.AW(AW)) u_port (
        .addr_i (bus_addr),
        .wen_i  (bus_wen),
        .wdata_i(bus_wdata),
        .pend_i (pend),
        .dis_i  (dis),
        .stb_o  (stb),
        .rdata_o(bus_rdata)
    );

    // R8: edges join the set path, which outranks clear
    assign pend_set_all = stb.pend_set | rise;

    sc_setclr_word #(.WIDTH(LINES), .RESET_VAL('0)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .set_i(pend_set_all),
        .clr_i(stb.pend_clr),
        .q_o  (pend)
    );

    sc_setclr_word #(.WIDTH(LINES), .RESET_VAL('1)) u_dis (
        .clk  (clk),
        .rst  (rst),
        .set_i(stb.dis_set),
        .clr_i(stb.dis_clr),
        .q_o  (dis)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |(pend & ~dis);
    end

    assert_irq_lag_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == |($past(pend) & ~$past(dis))));
    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(rise)) == $past(rise)));
    assert_reset_dis_R1: assert property (@(posedge clk)
        $past(rst) |-> (dis == '1 && pend == '0 && !irq_o));
endmodule

// File: tb/sc_irq_aggregator_test.sv
`timescale 1ns/1ps
module sc_irq_aggregator_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [31:0] m_pend, m_dis, m_prev;
    logic        m_irq;

    always #2 clk = ~clk;

    sc_irq_aggregator uut (
        .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        logic [31:0] e, sset, sclr, dset, dclr;
        if (rst) begin
            m_pend = '0; m_dis = '1; m_prev = '0; m_irq = 1'b0;
        end else begin
            e = src_i & ~m_prev;
            m_prev = src_i;
            m_irq = |(m_pend & ~m_dis);
            sset = (bus_wen && bus_addr == 5'h04) ? bus_wdata : '0;
            sclr = (bus_wen && bus_addr == 5'h08) ? bus_wdata : '0;
            dset = (bus_wen && bus_addr == 5'h10) ? bus_wdata : '0;
            dclr = (bus_wen && bus_addr == 5'h14) ? bus_wdata : '0;
            m_pend = (m_pend & ~sclr) | sset | e;
            m_dis  = (m_dis & ~dclr) | dset;
        end
    end

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        if (a == 5'h00) return m_pend;
        if (a == 5'h0C) return m_dis;
        return '0;
    endfunction

    function automatic string read_tag(input logic [4:0] a);
        if (a == 5'h00) return "R2/R3/R4";
        if (a == 5'h0C) return "R5";
        return "R9";
    endfunction

    task automatic step(input logic [31:0] s, input logic w, input logic [4:0] a,
                        input logic [31:0] d, input logic [4:0] ra, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        vectors++;
        if (irq_o !== m_irq) begin
            errors++;
            $display("FAIL R7 (%s) irq_o actual=%0b expected=%0b", tag, irq_o, m_irq);
        end
        bus_wen  = 1'b0;
        bus_addr = ra;
        #1;
        exp = exp_read(ra);
        vectors++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s (%s) read @%0h actual=%h expected=%h", read_tag(ra), tag, ra, bus_rdata, exp);
        end
        src_i = s; bus_wen = w; bus_addr = a; bus_wdata = d;
    endtask

    function automatic logic [4:0] pick_addr(input int unsigned r);
        case (r % 9)
            0: return 5'h00; 1: return 5'h04; 2: return 5'h08;
            3: return 5'h0C; 4: return 5'h10; 5: return 5'h14;
            6: return 5'h18; 7: return 5'h1C; default: return 5'h02;
        endcase
    endfunction

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        step('0, 0, 5'h00, '0, 5'h00, "R1 pend");
        step('0, 0, 5'h00, '0, 5'h0C, "R1 dis");
        // R6: raise line 3 while disabled
        step(32'h8, 0, 5'h00, '0, 5'h00, "R6");
        step(32'h0, 0, 5'h00, '0, 5'h00, "R6 latched R2");
        step(32'h0, 1, 5'h14, 32'h8, 5'h0C, "R6 no irq");
        step(32'h0, 0, 5'h00, '0, 5'h0C, "R6 enabled");
        step(32'h0, 0, 5'h00, '0, 5'h00, "R6 irq high");
        // R3 clear line 3, zero bits untouched
        step(32'h0, 1, 5'h08, 32'h8, 5'h00, "R3");
        step(32'h0, 0, 5'h00, '0, 5'h00, "R3 cleared");
        // R8 edge on line 5 with clear of line 5 same cycle
        step(32'h20, 1, 5'h08, 32'h20, 5'h00, "R8");
        step(32'h20, 0, 5'h00, '0, 5'h00, "R8 kept");
        // R10 hold line 5 high, clear, stays clear
        step(32'h20, 1, 5'h08, 32'h20, 5'h00, "R10");
        step(32'h20, 0, 5'h00, '0, 5'h00, "R10 clear");
        step(32'h20, 0, 5'h00, '0, 5'h00, "R10 held");
        // R4 software set
        step(32'h0, 1, 5'h04, 32'h8000_0001, 5'h00, "R4");
        step(32'h0, 0, 5'h00, '0, 5'h00, "R4 set");
        // R5 disable set / clear
        step(32'h0, 1, 5'h10, 32'h0000_0008, 5'h0C, "R5");
        step(32'h0, 1, 5'h14, 32'hF000_0000, 5'h0C, "R5 set");
        step(32'h0, 0, 5'h00, '0, 5'h0C, "R5 clr");
        // R9 unmapped writes ignored and alias reads zero
        step(32'h0, 1, 5'h18, 32'hFFFF_FFFF, 5'h04, "R9");
        step(32'h0, 1, 5'h02, 32'hFFFF_FFFF, 5'h14, "R9");
        step(32'h0, 0, 5'h00, '0, 5'h00, "R9 pend");
        step(32'h0, 0, 5'h00, '0, 5'h0C, "R9 dis");
        step(32'h0, 0, 5'h00, '0, 5'h1C, "R9 unmapped");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] s, d;
            s = $urandom & $urandom;
            d = $urandom & $urandom & $urandom;
            step(s, ($urandom % 2) == 0, pick_addr($urandom), d, pick_addr($urandom), "rand");
        end
        step('0, 0, 5'h00, '0, 5'h00, "final");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule